// File: doc/BRIEF.md
# Multi-Mode Sample FIFO Controller

This block holds up to 32 three-axis acceleration frames (X, Y and Z, 16 bits each) between a sample producer and a consumer that drains them in bursts. A frame arrives with a valid strobe. The oldest unread frame is always visible on the read outputs, and a read request removes it. The block reports an unread count, a watermark flag, a full-buffer flag and an empty flag, which the interrupt logic consumes.

A 2-bit field selects the fill policy. In pass-through, only the newest frame is kept. In hold, writes stop once the buffer is full. In ring, a write to a full buffer drops the oldest frame. In triggered capture, the block runs as a ring until a selected event arrives, then freezes as hold. A one-bit selector picks the triggering event: the motion event or the click event.

The policy is tracked by a state machine with the states ST_OFF, ST_PASS, ST_HOLD, ST_RING, ST_ARMED and ST_FIRED. It has three kinds of transition:
- Any state goes to ST_OFF whenever enable is low.
- A settle transition leaves ST_OFF, or leaves a state that does not match the requested mode. It enters the matching entry state (ST_PASS, ST_HOLD, ST_RING or ST_ARMED) and empties the buffer.
- The fire transition goes from ST_ARMED to ST_FIRED when the selected event is seen.

Top module: `sfifo_top`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, is_empty is 1, and unread, at_capacity and above_mark are 0.
- R2: Frames leave in arrival order. rd_x/rd_y/rd_z show the oldest unread frame whenever unread is nonzero. rd_req with a nonzero count removes that frame at the edge. rd_req on an empty buffer has no effect.
- R3: With fill_mode 2'b01 (hold), a write arriving while 32 frames are held is discarded, even if a read happens in the same cycle.
- R4: With fill_mode 2'b10 (ring), a write to a full buffer discards the oldest frame and the count stays 32.
- R5: With fill_mode 2'b00 (pass-through), the buffer holds at most one frame, and that frame is the most recently written one.
- R6: With fill_mode 2'b11 (triggered), writes follow the ring policy up to and including the cycle in which the selected event is high. From the next cycle on, they follow the hold policy. evt_sel 0 selects motion_evt and evt_sel 1 selects click_evt. The unselected event has no effect.
- R7: unread reports the number of held frames, saturated at 31.
- R8: above_mark is 1 exactly when the number of held frames is greater than mark_lvl.
- R9: at_capacity is 1 exactly when 32 frames are held. is_empty is 1 exactly when no frame is held.
- R10: A cycle in which en is low, or in which en is high but fill_mode (or en) differs from the previous cycle, empties the buffer at its edge. Such a cycle ignores that cycle's write and read, and re-arms the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Buffer enable |
| fill_mode | input | 2 | Policy: 00 pass, 01 hold, 10 ring, 11 triggered |
| evt_sel | input | 1 | Trigger source: 0 motion, 1 click |
| motion_evt | input | 1 | Motion event pulse |
| click_evt | input | 1 | Click event pulse |
| mark_lvl | input | 5 | Watermark level |
| wr_valid | input | 1 | Frame write strobe |
| wr_x | input | 16 | X sample in |
| wr_y | input | 16 | Y sample in |
| wr_z | input | 16 | Z sample in |
| rd_req | input | 1 | Remove oldest frame |
| rd_x | output | 16 | X of oldest frame |
| rd_y | output | 16 | Y of oldest frame |
| rd_z | output | 16 | Z of oldest frame |
| unread | output | 5 | Unread count, saturated at 31 |
| above_mark | output | 1 | Count above watermark |
| at_capacity | output | 1 | 32 frames held |
| is_empty | output | 1 | No frame held |

## Verification
The temporal checks take for granted that all inputs are stable across the clock edge. They also assume that the policy in force in a cycle is fully determined by en and fill_mode having held in the previous cycle, so the mode checks are guarded by the previous cycle's en and fill_mode. The bench drives every input on the falling edge and keeps configuration fields constant for several cycles in the directed phases. It changes them only at falling edges in the random phase, so each settle cycle is a whole clock and each mode check sees one settled policy.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        FM_PASS = 2'b00,
        FM_HOLD = 2'b01,
        FM_RING = 2'b10,
        FM_TRIG = 2'b11
    } fill_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PASS,
        ST_HOLD,
        ST_RING,
        ST_ARMED,
        ST_FIRED
    } pol_state_e;

    localparam int AXES = 3;
endpackage

// File: rtl/sfifo_policy.sv
module sfifo_policy
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] fill_mode,
    input  logic       evt_sel,
    input  logic       motion_evt,
    input  logic       click_evt,
    output logic       flush,
    output logic       overwrite,
    output logic       depth_one
);
    pol_state_e state_q, state_d;
    logic       match;
    logic       fire;

    assign fire = evt_sel ? click_evt : motion_evt;

    always_comb begin
        unique case (state_q)
            ST_OFF:            match = 1'b0;
            ST_PASS:           match = (fill_mode == FM_PASS);
            ST_HOLD:           match = (fill_mode == FM_HOLD);
            ST_RING:           match = (fill_mode == FM_RING);
            ST_ARMED, ST_FIRED: match = (fill_mode == FM_TRIG);
            default:           match = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else if (!match) begin
            unique case (fill_mode)
                FM_PASS: state_d = ST_PASS;
                FM_HOLD: state_d = ST_HOLD;
                FM_RING: state_d = ST_RING;
                default: state_d = ST_ARMED;
            endcase
        end else if (state_q == ST_ARMED && fire) begin
            state_d = ST_FIRED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        flush     = !en || !match;
        overwrite = 1'b0;
        depth_one = 1'b0;
        unique case (state_q)
            ST_PASS:  begin overwrite = 1'b1; depth_one = 1'b1; end
            ST_RING:  overwrite = 1'b1;
            ST_ARMED: overwrite = 1'b1;
            default:  overwrite = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfifo_ptrs.sv
module sfifo_ptrs #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          overwrite,
    input  logic          depth_one,
    input  logic          wr_valid,
    input  logic          rd_req,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cap;
    logic          full, pop, accept, drop, adv;

    assign cap    = depth_one ? CW'(1) : CW'(DEPTH);
    assign full   = (count == cap);
    assign pop    = rd_req && (count != '0);
    assign accept = wr_valid && (!full || overwrite);
    assign drop   = accept && full && !pop;
    assign adv    = pop || drop;
    assign wr_en  = accept && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_addr <= '0;
            rd_addr <= '0;
            count   <= '0;
        end else begin
            wr_addr <= wr_addr + AW'(accept);
            rd_addr <= rd_addr + AW'(adv);
            count   <= count + CW'(accept) - CW'(adv);
        end
    end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int SW    = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [AW-1:0]      rd_addr,
    input  logic [AXES*SW-1:0] wr_frame,
    output logic [AXES*SW-1:0] rd_frame
);
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic [SW-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en) cells[wr_addr] <= wr_frame[a*SW +: SW];
        end
        assign rd_frame[a*SW +: SW] = cells[rd_addr];
    end
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top #(
    parameter int DEPTH = 32,
    parameter int SW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    fill_mode,
    input  logic          evt_sel,
    input  logic          motion_evt,
    input  logic          click_evt,
    input  logic [AW-1:0] mark_lvl,
    input  logic          wr_valid,
    input  logic [SW-1:0] wr_x,
    input  logic [SW-1:0] wr_y,
    input  logic [SW-1:0] wr_z,
    input  logic          rd_req,
    output logic [SW-1:0] rd_x,
    output logic [SW-1:0] rd_y,
    output logic [SW-1:0] rd_z,
    output logic [AW-1:0] unread,
    output logic          above_mark,
    output logic          at_capacity,
    output logic          is_empty
);
    logic          flush, overwrite, depth_one, wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] count;
    logic [3*SW-1:0] rd_frame;

    sfifo_policy u_policy (
        .clk(clk), .rst_n(rst_n), .en(en), .fill_mode(fill_mode),
        .evt_sel(evt_sel), .motion_evt(motion_evt), .click_evt(click_evt),
        .flush(flush), .overwrite(overwrite), .depth_one(depth_one)
    );

    sfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .flush(flush), .overwrite(overwrite),
        .depth_one(depth_one), .wr_valid(wr_valid), .rd_req(rd_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .count(count)
    );

    sfifo_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .wr_frame({wr_z, wr_y, wr_x}), .rd_frame(rd_frame)
    );

    assign {rd_z, rd_y, rd_x} = rd_frame;
    assign at_capacity = (count == CW'(DEPTH));
    assign is_empty    = (count == '0);
    assign unread      = at_capacity ? {AW{1'b1}} : count[AW-1:0];
    assign above_mark  = (count > {1'b0, mark_lvl});
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
    parameter int SW = 16,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [1:0]    fill_mode,
    input logic          wr_valid,
    input logic          rd_req,
    input logic [AW-1:0] mark_lvl,
    input logic [SW-1:0] rd_x,
    input logic [AW-1:0] unread,
    input logic          above_mark,
    input logic          at_capacity,
    input logic          is_empty
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> is_empty && !at_capacity && !above_mark);

    // R2
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty && !wr_valid |=> is_empty);

    // R3
    hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && fill_mode == 2'b01 && $past(fill_mode) == 2'b01
        && at_capacity && !rd_req |=> at_capacity && $stable(rd_x));

    // R3
    hold_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && fill_mode == 2'b01 && $past(fill_mode) == 2'b01
        && at_capacity && rd_req |=> !at_capacity);

    // R4
    ring_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && fill_mode == 2'b10 && $past(fill_mode) == 2'b10
        && at_capacity && wr_valid |=> at_capacity);

    // R5
    pass_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && fill_mode == 2'b00 && $past(fill_mode) == 2'b00
        |-> unread <= AW'(1));

    // R8
    mark_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unread > mark_lvl |-> above_mark);

    // R8
    mark_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !above_mark |-> unread <= mark_lvl);

    // R9
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_capacity |-> !is_empty && unread == {AW{1'b1}});

    // R10
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> is_empty);
endmodule

bind sfifo_top sfifo_chk #(.SW(SW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .fill_mode(fill_mode),
    .wr_valid(wr_valid), .rd_req(rd_req), .mark_lvl(mark_lvl),
    .rd_x(rd_x), .unread(unread), .above_mark(above_mark),
    .at_capacity(at_capacity), .is_empty(is_empty)
);

// File: tb/sfifo_top_bench.sv
module sfifo_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  fill_mode = 2'b00;
    logic        evt_sel = 1'b0;
    logic        motion_evt = 1'b0;
    logic        click_evt = 1'b0;
    logic [4:0]  mark_lvl = 5'd0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_x = '0, wr_y = '0, wr_z = '0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_x, rd_y, rd_z;
    logic [4:0]  unread;
    logic        above_mark, at_capacity, is_empty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] q[$];
    bit          m_act = 0;
    logic [1:0]  m_mode = 2'b00;
    bit          m_fired = 0;
    int          seq = 1;

    always #10 clk = ~clk;

    sfifo_top u_sfifo_top (
        .clk(clk), .rst_n(rst_n), .en(en), .fill_mode(fill_mode),
        .evt_sel(evt_sel), .motion_evt(motion_evt), .click_evt(click_evt),
        .mark_lvl(mark_lvl), .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y),
        .wr_z(wr_z), .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z),
        .unread(unread), .above_mark(above_mark), .at_capacity(at_capacity),
        .is_empty(is_empty)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            q.delete(); m_act = 0;
        end else if (!en) begin
            q.delete(); m_act = 0;
        end else if (!m_act || m_mode != fill_mode) begin
            q.delete(); m_act = 1; m_mode = fill_mode; m_fired = 0;
        end else begin
            int  cap  = (m_mode == 2'b00) ? 1 : 32;
            bit  ring = (m_mode == 2'b00) || (m_mode == 2'b10) ||
                        (m_mode == 2'b11 && !m_fired);
            bit  full = (q.size() == cap);
            bit  pop  = rd_req && (q.size() > 0);
            if (pop) void'(q.pop_front());
            if (wr_valid) begin
                if (!full) q.push_back({wr_z, wr_y, wr_x});
                else if (ring) begin
                    if (!pop) void'(q.pop_front());
                    q.push_back({wr_z, wr_y, wr_x});
                end
            end
            if (m_mode == 2'b11 && !m_fired && (evt_sel ? click_evt : motion_evt))
                m_fired = 1;
        end
    endtask

    task automatic compare(string tag);
        int n = q.size();
        chk("R7", 64'(unread), 64'((n > 31) ? 31 : n), {tag, " unread"});
        chk("R9", 64'(at_capacity), 64'(n == 32), "at_capacity");
        chk("R9", 64'(is_empty), 64'(n == 0), "is_empty");
        chk("R8", 64'(above_mark), 64'(n > int'(mark_lvl)), "above_mark");
        if (n > 0) chk(tag, 64'({rd_z, rd_y, rd_x}), 64'(q[0]), "head frame");
    endtask

    task automatic step(string tag, bit v, bit r);
        wr_valid = v;
        rd_req   = r;
        wr_x = 16'(seq); wr_y = 16'(seq) ^ 16'h5a5a; wr_z = ~16'(seq);
        if (v) seq++;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        motion_evt = 1'b0;
        click_evt  = 1'b0;
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 64'(is_empty), 64'd1, "is_empty in reset");
        chk("R1", 64'(unread), 64'd0, "unread in reset");
        chk("R1", 64'(at_capacity), 64'd0, "at_capacity in reset");
        chk("R1", 64'(above_mark), 64'd0, "above_mark in reset");
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step("R10", 1, 0);   // disabled: ignored
        chk("R1", 64'(is_empty), 64'd1, "empty after release");

        // R3 hold mode
        en = 1'b1; fill_mode = 2'b01; mark_lvl = 5'd4;
        for (int i = 0; i < 40; i++) step("R3", 1, 0);
        chk("R3", 64'(at_capacity), 64'd1, "full in hold");
        step("R3", 1, 1);
        chk("R3", 64'(unread), 64'd31, "write dropped while reading");
        for (int i = 0; i < 33; i++) step("R2", 0, 1);
        step("R2", 0, 1);

        // R4 ring mode
        fill_mode = 2'b10;
        for (int i = 0; i < 40; i++) step("R4", 1, 0);
        for (int i = 0; i < 5; i++) step("R4", 1, 1);
        for (int i = 0; i < 6; i++) step("R2", 0, 1);

        // R5 pass-through
        fill_mode = 2'b00;
        for (int i = 0; i < 5; i++) step("R5", 1, 0);
        step("R5", 0, 1);
        step("R5", 0, 1);
        step("R5", 1, 1);
        step("R5", 1, 0);

        // R6 triggered, motion source
        fill_mode = 2'b11; evt_sel = 1'b0;
        for (int i = 0; i < 36; i++) begin
            if (i == 10) click_evt = 1'b1;
            step("R6", 1, 0);
        end
        for (int i = 0; i < 4; i++) step("R6", 0, 1);
        motion_evt = 1'b1;
        step("R6", 1, 0);
        for (int i = 0; i < 10; i++) step("R6", 1, 0);
        chk("R6", 64'(at_capacity), 64'd1, "frozen after motion event");

        // R6 triggered, click source, rearmed by mode change
        fill_mode = 2'b10; step("R10", 1, 0);
        fill_mode = 2'b11; evt_sel = 1'b1;
        for (int i = 0; i < 20; i++) step("R6", 1, 0);
        motion_evt = 1'b1; step("R6", 1, 0);
        click_evt = 1'b1;  step("R6", 1, 0);
        for (int i = 0; i < 20; i++) step("R6", 1, 0);

        // R8 watermark edges, in hold mode
        fill_mode = 2'b01; mark_lvl = 5'd31;
        for (int i = 0; i < 33; i++) step("R8", 1, 0);
        mark_lvl = 5'd0;
        step("R8", 0, 0);
        for (int i = 0; i < 32; i++) step("R8", 0, 1);

        // R10 disable while holding data
        for (int i = 0; i < 8; i++) step("R10", 1, 0);
        en = 1'b0; step("R10", 1, 0);
        en = 1'b1; step("R10", 1, 0);
        step("R10", 1, 0);

        // mixed random traffic
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 150) == 0) fill_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 400) == 0) en = 1'b0;
            else if (!en && $urandom_range(0, 3) == 0) en = 1'b1;
            if ($urandom_range(0, 60) == 0) evt_sel = ~evt_sel;
            if ($urandom_range(0, 40) == 0) motion_evt = 1'b1;
            if ($urandom_range(0, 40) == 0) click_evt = 1'b1;
            if ($urandom_range(0, 100) == 0) mark_lvl = 5'($urandom_range(0, 31));
            step("R2", ($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 4));
        end

        done = 1;
        report();
    end
endmodule